// File: doc/BRIEF.md
# Split Stack and Bank Address Incrementer

This block keeps a 24-bit address as two separately stepped parts. The low part is a 16-bit pointer that moves up or down by one in a single clock. It serves as the stack pointer: a pull moves it up and a push moves it down. The high part is an 8-bit bank byte with its own incrementer. The low part never ripples into the bank in the same cycle.

When the low pointer wraps, it raises a flag for one cycle. Going up past 0xFFFF raises a carry flag. Going down below 0x0000 raises a borrow flag. The flag is exported as a stall request, so a sequencer can spend one extra cycle on the bank update. Ordinary pushes and pulls that do not wrap cost no extra cycle. Both parts have a synchronous load. With no load and no step, both parts hold.

Top module: `addr_step_unit`

## Requirements
- R1: While `rst_n` is low, `ptr_q`, `bank_q`, `wrap_carry`, `wrap_borrow` and `stall_req` are all zero.
- R2: When `ptr_step` is 1, `ptr_dir` is 0 (pull) and `ptr_load` is 0, `ptr_q` holds the old value plus one (mod 65536) after the next rising edge.
- R3: When `ptr_step` is 1, `ptr_dir` is 1 (push) and `ptr_load` is 0, `ptr_q` holds the old value minus one (mod 65536) after the next rising edge.
- R4: When `ptr_load` is 1, `ptr_q` takes `ptr_load_val` at the next edge, whatever `ptr_step` is. Both wrap flags are then 0.
- R5: When both `ptr_load` and `ptr_step` are 0, `ptr_q` is unchanged after the edge and both wrap flags are 0.
- R6: An upward step from 0xFFFF sets `wrap_carry` to 1. A downward step from 0x0000 sets `wrap_borrow` to 1. The flag appears in the same cycle as the wrapped result and lasts exactly one cycle. The two flags are never 1 together.
- R7: If `wrap_carry` is 1 and `bank_step_en` is 1, `bank_q` increments by one (mod 256) at the closing edge of that cycle, unless `bank_load` is 1. `wrap_borrow` never changes `bank_q`.
- R8: `bank_load` loads `bank_load_val` and takes priority over the bank increment. With `bank_load` at 0, `bank_q` holds whenever `wrap_carry` or `bank_step_en` is 0.
- R9: `stall_req` equals `wrap_carry` OR `wrap_borrow`. `addr_q` is `{bank_q, ptr_q}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_load | input | 1 | Load the low pointer |
| ptr_load_val | input | 16 | Value to load into the low pointer |
| ptr_step | input | 1 | Step the low pointer by one |
| ptr_dir | input | 1 | Step direction: 0 up (pull), 1 down (push) |
| bank_load | input | 1 | Load the bank byte |
| bank_load_val | input | 8 | Value to load into the bank byte |
| bank_step_en | input | 1 | Allow a carry to advance the bank |
| ptr_q | output | 16 | Low pointer |
| bank_q | output | 8 | Bank byte |
| addr_q | output | 24 | Combined address |
| wrap_carry | output | 1 | Low pointer wrapped upward in the last step |
| wrap_borrow | output | 1 | Low pointer wrapped downward in the last step |
| stall_req | output | 1 | Extra-cycle request for the bank update |

## Verification
Random cycles mix loads, pull steps, push steps and idle cycles. Loads are steered toward 0x0000, 0xFFFF and their neighbours, so wraps happen often. This separates a wrong direction, a wrong priority between load and step, and a flag that lingers or is raised early. Directed runs then cover four cases: a carry with the bank enabled, a carry with the bank disabled, a borrow with the bank enabled, and a bank load that collides with a carry. Together they show the bank moves only one cycle after an upward wrap and only when enabled.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;
  typedef enum logic {
    STEP_UP = 1'b0,
    STEP_DN = 1'b1
  } step_dir_e;
endpackage

// File: rtl/ptr_updown.sv
module ptr_updown
  import addr_step_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  step_dir_e    dir,
  output logic [W-1:0] ptr_q,
  output logic         carry_q,
  output logic         borrow_q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] ptr_d;
  logic         carry_d, borrow_d;
  logic [W:0]   up_sum, dn_diff;

  assign up_sum  = {1'b0, ptr_q} + {{W{1'b0}}, 1'b1};
  assign dn_diff = {1'b0, ptr_q} - {{W{1'b0}}, 1'b1};

  always_comb begin
    ptr_d    = ptr_q;
    carry_d  = 1'b0;
    borrow_d = 1'b0;
    if (load) begin
      ptr_d = load_val;
    end else if (step) begin
      if (dir == STEP_DN) begin
        ptr_d    = dn_diff[W-1:0];
        borrow_d = dn_diff[W];
      end else begin
        ptr_d   = up_sum[W-1:0];
        carry_d = up_sum[W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      carry_q  <= carry_d;
      borrow_q <= borrow_d;
    end
  end

  AST_PTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dir == STEP_UP) |=> ptr_q == W'($past(ptr_q) + 1'b1)); // R2
  AST_PTR_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dir == STEP_DN) |=> ptr_q == W'($past(ptr_q) - 1'b1)); // R3
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr_q == $past(load_val)) && !carry_q && !borrow_q); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(ptr_q) && !carry_q && !borrow_q); // R5
  AST_CARRY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    carry_q |-> ptr_q == '0); // R6
  AST_BORROW_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_q |-> ptr_q == ALL_ONES); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_q && borrow_q)); // R6
endmodule

// File: rtl/bank_inc.sv
module bank_inc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         carry_in,
  input  logic         step_en,
  output logic [W-1:0] bank_q
);
  logic [W-1:0] bank_d;
  logic         adv;

  assign adv = carry_in && step_en;

  always_comb begin
    bank_d = bank_q;
    if (load)     bank_d = load_val;
    else if (adv) bank_d = bank_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  AST_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_in && step_en && !load) |=> bank_q == W'($past(bank_q) + 1'b1)); // R7
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bank_q == $past(load_val)); // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(carry_in && step_en)) |=> $stable(bank_q)); // R8
endmodule

// File: rtl/addr_step_unit.sv
module addr_step_unit
  import addr_step_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int BANK_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ptr_load,
  input  logic [PTR_W-1:0]          ptr_load_val,
  input  logic                      ptr_step,
  input  logic                      ptr_dir,
  input  logic                      bank_load,
  input  logic [BANK_W-1:0]         bank_load_val,
  input  logic                      bank_step_en,
  output logic [PTR_W-1:0]          ptr_q,
  output logic [BANK_W-1:0]         bank_q,
  output logic [PTR_W+BANK_W-1:0]   addr_q,
  output logic                      wrap_carry,
  output logic                      wrap_borrow,
  output logic                      stall_req
);
  step_dir_e dir_e;
  assign dir_e = step_dir_e'(ptr_dir);

  ptr_updown #(.W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .step     (ptr_step),
    .dir      (dir_e),
    .ptr_q    (ptr_q),
    .carry_q  (wrap_carry),
    .borrow_q (wrap_borrow)
  );

  bank_inc #(.W(BANK_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bank_load),
    .load_val (bank_load_val),
    .carry_in (wrap_carry),
    .step_en  (bank_step_en),
    .bank_q   (bank_q)
  );

  assign addr_q    = {bank_q, ptr_q};
  assign stall_req = wrap_carry | wrap_borrow;

  AST_BORROW_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_borrow && !bank_load) |=> $stable(bank_q)); // R7
  AST_STALL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (ptr_q == '0 || ptr_q == {PTR_W{1'b1}})); // R9
endmodule

// File: tb/addr_step_unit_tb.sv
module addr_step_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ptr_load, ptr_step, ptr_dir, bank_load, bank_step_en;
  logic [15:0] ptr_load_val;
  logic [7:0]  bank_load_val;
  logic [15:0] ptr_q;
  logic [7:0]  bank_q;
  logic [23:0] addr_q;
  logic        wrap_carry, wrap_borrow, stall_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_ptr;
  logic [7:0]  m_bank;
  logic        m_c, m_b;

  always #2 clk = ~clk;

  addr_step_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .ptr_step(ptr_step), .ptr_dir(ptr_dir),
    .bank_load(bank_load), .bank_load_val(bank_load_val),
    .bank_step_en(bank_step_en),
    .ptr_q(ptr_q), .bank_q(bank_q), .addr_q(addr_q),
    .wrap_carry(wrap_carry), .wrap_borrow(wrap_borrow), .stall_req(stall_req)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt_ptr(input logic ld, input logic [15:0] lv,
                                          input logic st, input logic dn, input logic [15:0] p);
    if (ld) return lv;
    if (st) return dn ? p - 16'd1 : p + 16'd1;
    return p;
  endfunction

  function automatic logic [7:0] nxt_bank(input logic ld, input logic [7:0] lv,
                                          input logic c, input logic en, input logic [7:0] b);
    if (ld) return lv;
    if (c && en) return b + 8'd1;
    return b;
  endfunction

  task automatic compare_all(input string ptr_tag, input string bank_tag);
    chk(ptr_tag, "ptr_q", 32'(ptr_q), 32'(m_ptr));
    chk("R6", "wrap_carry", 32'(wrap_carry), 32'(m_c));
    chk("R6", "wrap_borrow", 32'(wrap_borrow), 32'(m_b));
    chk(bank_tag, "bank_q", 32'(bank_q), 32'(m_bank));
    chk("R9", "stall_req", 32'(stall_req), 32'(m_c | m_b));
    chk("R9", "addr_q", 32'(addr_q), 32'({m_bank, m_ptr}));
  endtask

  // Drive one cycle at a falling edge, then compare after the next falling edge.
  task automatic cyc(input logic ld, input logic [15:0] lv, input logic st, input logic dn,
                     input logic bld, input logic [7:0] blv, input logic ben);
    logic [15:0] np;
    logic [7:0]  nb;
    logic        nc, nbw;
    string       pt, bt;
    ptr_load = ld; ptr_load_val = lv; ptr_step = st; ptr_dir = dn;
    bank_load = bld; bank_load_val = blv; bank_step_en = ben;
    np  = nxt_ptr(ld, lv, st, dn, m_ptr);
    nc  = !ld && st && !dn && (m_ptr == 16'hFFFF);
    nbw = !ld && st && dn && (m_ptr == 16'h0000);
    nb  = nxt_bank(bld, blv, m_c, ben, m_bank);
    pt  = ld ? "R4" : (st ? (dn ? "R3" : "R2") : "R5");
    bt  = (!bld && m_c && ben) ? "R7" : "R8";
    @(posedge clk);
    @(negedge clk);
    m_ptr = np; m_bank = nb; m_c = nc; m_b = nbw;
    compare_all(pt, bt);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lv;
    int r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    ptr_load = 0; ptr_load_val = 0; ptr_step = 0; ptr_dir = 0;
    bank_load = 0; bank_load_val = 0; bank_step_en = 0;
    m_ptr = 0; m_bank = 0; m_c = 0; m_b = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ptr_q", 32'(ptr_q), 32'h0);
    chk("R1", "bank_q", 32'(bank_q), 32'h0);
    chk("R1", "flags", 32'({wrap_carry, wrap_borrow, stall_req}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: upward wrap with bank enabled (R6, R7)
    cyc(1, 16'hFFFE, 0, 0, 1, 8'h12, 0);
    cyc(0, 0, 1, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0, 0, 1);             // wraps to 0000, carry now visible
    chk("R6", "carry on wrap", 32'(wrap_carry), 32'h1);
    cyc(0, 0, 0, 0, 0, 0, 1);             // bank advances this edge
    chk("R7", "bank after carry", 32'(bank_q), 32'h13);
    chk("R6", "carry one cycle", 32'(wrap_carry), 32'h0);
    // Carry with bank disabled (R8)
    cyc(1, 16'hFFFF, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R8", "bank held with enable low", 32'(bank_q), 32'h13);
    // Downward wrap with bank enabled: no bank change (R3, R6, R7)
    cyc(1, 16'h0000, 0, 0, 0, 0, 1);
    cyc(0, 0, 1, 1, 0, 0, 1);
    chk("R6", "borrow on wrap", 32'(wrap_borrow), 32'h1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R7", "borrow leaves bank", 32'(bank_q), 32'h13);
    // Bank load collides with carry (R8)
    cyc(1, 16'hFFFF, 0, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 8'hA0, 1);
    chk("R8", "load beats carry", 32'(bank_q), 32'hA0);
    // Load wins over step (R4)
    cyc(1, 16'h1234, 1, 1, 0, 0, 0);
    chk("R4", "load beats step", 32'(ptr_q), 32'h1234);

    // Random phase
    for (int i = 0; i < 2000; i++) begin
      r = int'($urandom_range(0, 9));
      case ($urandom_range(0, 3))
        0: lv = 16'h0000;
        1: lv = 16'hFFFF;
        2: lv = 16'(16'hFFFE + $urandom_range(0, 3));
        default: lv = 16'($urandom());
      endcase
      cyc(r == 0, lv, r > 1, 1'($urandom()), $urandom_range(0, 15) == 0,
          8'($urandom()), 1'($urandom()));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule